// File: doc/BRIEF.md
# Charger Control Register Bank with Command Watchdog

This block holds the host-programmable control state of a battery charger: two option bytes, a 16-bit charge-current command and a 16-bit charge-voltage command. The host reaches all six bytes through a byte-addressed write port and a combinational read port. The bank drives the register contents to the rest of the charger. It also drives an effective charge-current value, which is zero while the charge-inhibit bit is set.

A programmable watchdog guards against a host that has stopped responding. The host must rewrite the current or voltage command within the selected period, counted in ticks of a 1 ms strobe input. If it does not, the bank forces the charge-current command to zero. It raises a one-clock expiry pulse and a sticky expired flag. Separately, when the battery-presence input is low, hardware clears the learn-mode bit. If the auto-disable option is set, hardware also clears the input-current-limit enable bit.

Top module: `chg_ctrl_regs`

## Requirements
- R1: After reset the lower option byte reads 0x0E, the upper option byte reads 0xE7, and both command words read 0x0000.
- R2: A write with `wr_en` high stores `wr_data` at the addressed byte: 0 lower option, 1 upper option, 2/3 current command low/high, 4/5 voltage command low/high. Writes to addresses 6 and 7 change nothing.
- R3: Upper option bits [6:5] select the watchdog: 00 off, 01 WD_T1 ticks, 10 WD_T2 ticks, 11 WD_T3 ticks. Expiry occurs on the clock of the Nth tick after the last refresh.
- R4: On expiry the current command becomes 0x0000, `wd_pulse` is high for exactly one clock, `wd_expired` rises, and the voltage command is not changed.
- R5: A write to address 1, 2, 3, 4 or 5 is a refresh. It clears the tick count and `wd_expired`. `wd_expired` stays set, and no further ticks are counted, until such a write.
- R6: With select 00 the count is held at zero and no expiry happens, however many ticks arrive.
- R7: A current-command write on the clock that would expire the watchdog wins: the written byte is kept and no expiry occurs.
- R8: While `bat_present` is low, lower option bit 5 (learn enable) is forced to 0, including against a host write in the same cycle.
- R9: While `bat_present` is low and upper option bit 4 (auto-disable) is 1, lower option bit 1 (current-limit enable) is forced to 0. With auto-disable 0 the bit is kept, and the host may set it again once `bat_present` is high.
- R10: `ichg_eff` equals the current command when lower option bit 0 (inhibit) is 0, and is 0x0000 when it is 1.
- R11: `rd_data` shows the byte at `rd_addr` in the same cycle; addresses 6 and 7 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 3 | Write byte address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read byte address |
| rd_data | output | 8 | Read data for `rd_addr` |
| tick_1ms | input | 1 | Watchdog timebase strobe, one clock per tick |
| bat_present | input | 1 | Battery presence, low when absent |
| opt_lo | output | 8 | Lower option byte |
| opt_hi | output | 8 | Upper option byte |
| ichg_word | output | 16 | Charge-current command |
| vchg_word | output | 16 | Charge-voltage command |
| ichg_eff | output | 16 | Effective charge current after inhibit |
| wd_pulse | output | 1 | One-clock watchdog expiry pulse |
| wd_expired | output | 1 | Sticky watchdog expired flag |

## Verification
The bench measures the expiry distance for each of the three select codes. An off-by-one counter would expire one tick early or late and fail the count. It lands a current-command write exactly on the would-be expiry clock; a design that lets the forced zero win would lose the written byte. It holds the expired state for many cycles to catch a flag that self-clears or a counter that keeps running, and it sets select 00 under continuous ticks to catch a disabled timer that still fires. The battery-absent cases run with auto-disable both on and off, and include a host write racing the hardware clear. A design that clears the wrong bit, or clears regardless of auto-disable, shows up in the option byte.

// File: rtl/chg_regs_pkg.sv
package chg_regs_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_OPT_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_OPT_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_ICH_L  = 3'd2;
    localparam logic [ADDR_W-1:0] A_ICH_H  = 3'd3;
    localparam logic [ADDR_W-1:0] A_VCH_L  = 3'd4;
    localparam logic [ADDR_W-1:0] A_VCH_H  = 3'd5;

    // upper option byte fields
    localparam int HI_WSEL_LSB = 5;
    localparam int HI_AUTODIS  = 4;
    // lower option byte fields
    localparam int LO_LEARN    = 5;
    localparam int LO_ILIM     = 1;
    localparam int LO_INHIBIT  = 0;

    localparam logic [7:0] OPT_LO_RST = 8'h0E;
    localparam logic [7:0] OPT_HI_RST = 8'hE7;

    typedef struct packed {
        logic [7:0]  opt_lo;
        logic [7:0]  opt_hi;
        logic [15:0] ichg;
        logic [15:0] vchg;
    } chg_regs_t;

endpackage

// File: rtl/chg_wdog.sv
module chg_wdog #(
    parameter int T1 = 5000,
    parameter int T2 = 88000,
    parameter int T3 = 175000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel_i,
    input  logic       refresh_i,
    input  logic       tick_i,
    output logic       expire_now_o,
    output logic       expired_o,
    output logic       pulse_o
);
    localparam int CNT_W = $clog2(T3 + 1);
    localparam logic [CNT_W-1:0] L1 = CNT_W'(T1 - 1);
    localparam logic [CNT_W-1:0] L2 = CNT_W'(T2 - 1);
    localparam logic [CNT_W-1:0] L3 = CNT_W'(T3 - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             expired;
        logic             pulse;
    } wd_t;

    wd_t wd_d, wd_q;
    logic [CNT_W-1:0] last_d;
    logic             armed;

    always_comb begin
        case (sel_i)
            2'b01:   last_d = L1;
            2'b10:   last_d = L2;
            default: last_d = L3;
        endcase
        armed        = (sel_i != 2'b00);
        expire_now_o = !refresh_i && armed && !wd_q.expired && tick_i
                       && (wd_q.cnt == last_d);

        wd_d       = wd_q;
        wd_d.pulse = expire_now_o;
        if (refresh_i) begin
            wd_d.cnt     = '0;
            wd_d.expired = 1'b0;
        end else if (expire_now_o) begin
            wd_d.cnt     = '0;
            wd_d.expired = 1'b1;
        end else if (!armed) begin
            wd_d.cnt = '0;
        end else if (!wd_q.expired && tick_i) begin
            wd_d.cnt = wd_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wd_q <= '0;
        else        wd_q <= wd_d;
    end

    assign expired_o = wd_q.expired;
    assign pulse_o   = wd_q.pulse;

    // R4: the expiry pulse lasts a single clock
    p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);
    // R5: expired flag holds until a refresh
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !refresh_i) |=> expired_o);
    // R5: a refresh clears the flag
    p_refresh_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_i |=> !expired_o);
    // R6: select 00 never expires
    p_off_no_expire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 2'b00) |=> !pulse_o);

endmodule

// File: rtl/chg_rd_mux.sv
module chg_rd_mux
    import chg_regs_pkg::*;
(
    input  chg_regs_t         regs_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [7:0]        data_o
);
    always_comb begin
        case (addr_i)
            A_OPT_LO: data_o = regs_i.opt_lo;
            A_OPT_HI: data_o = regs_i.opt_hi;
            A_ICH_L:  data_o = regs_i.ichg[7:0];
            A_ICH_H:  data_o = regs_i.ichg[15:8];
            A_VCH_L:  data_o = regs_i.vchg[7:0];
            A_VCH_H:  data_o = regs_i.vchg[15:8];
            default:  data_o = 8'h00;
        endcase
    end
endmodule

// File: rtl/chg_ctrl_regs.sv
module chg_ctrl_regs
    import chg_regs_pkg::*;
#(
    parameter int WD_T1 = 5000,
    parameter int WD_T2 = 88000,
    parameter int WD_T3 = 175000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic [2:0]  rd_addr,
    output logic [7:0]  rd_data,
    input  logic        tick_1ms,
    input  logic        bat_present,
    output logic [7:0]  opt_lo,
    output logic [7:0]  opt_hi,
    output logic [15:0] ichg_word,
    output logic [15:0] vchg_word,
    output logic [15:0] ichg_eff,
    output logic        wd_pulse,
    output logic        wd_expired
);
    chg_regs_t regs_d, regs_q;
    logic      refresh;
    logic      expire_now;

    always_comb begin
        refresh = wr_en && (wr_addr == A_OPT_HI || wr_addr == A_ICH_L ||
                            wr_addr == A_ICH_H  || wr_addr == A_VCH_L ||
                            wr_addr == A_VCH_H);
        regs_d = regs_q;
        if (wr_en) begin
            case (wr_addr)
                A_OPT_LO: regs_d.opt_lo      = wr_data;
                A_OPT_HI: regs_d.opt_hi      = wr_data;
                A_ICH_L:  regs_d.ichg[7:0]   = wr_data;
                A_ICH_H:  regs_d.ichg[15:8]  = wr_data;
                A_VCH_L:  regs_d.vchg[7:0]   = wr_data;
                A_VCH_H:  regs_d.vchg[15:8]  = wr_data;
                default:  ;
            endcase
        end
        // expiry is suppressed in any refresh cycle, so a host write never collides
        if (expire_now) regs_d.ichg = '0;
        if (!bat_present) begin
            regs_d.opt_lo[LO_LEARN] = 1'b0;
            if (regs_q.opt_hi[HI_AUTODIS]) regs_d.opt_lo[LO_ILIM] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.opt_lo <= OPT_LO_RST;
            regs_q.opt_hi <= OPT_HI_RST;
            regs_q.ichg   <= '0;
            regs_q.vchg   <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    chg_wdog #(.T1(WD_T1), .T2(WD_T2), .T3(WD_T3)) wdog_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel_i        (regs_q.opt_hi[HI_WSEL_LSB +: 2]),
        .refresh_i    (refresh),
        .tick_i       (tick_1ms),
        .expire_now_o (expire_now),
        .expired_o    (wd_expired),
        .pulse_o      (wd_pulse)
    );

    chg_rd_mux rd_mux_i (
        .regs_i (regs_q),
        .addr_i (rd_addr),
        .data_o (rd_data)
    );

    assign opt_lo    = regs_q.opt_lo;
    assign opt_hi    = regs_q.opt_hi;
    assign ichg_word = regs_q.ichg;
    assign vchg_word = regs_q.vchg;
    assign ichg_eff  = regs_q.opt_lo[LO_INHIBIT] ? 16'h0000 : regs_q.ichg;

    // R4: the expiry pulse coincides with a zeroed current command
    p_forced_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wd_pulse |-> (ichg_word == 16'h0000));
    // R4: expiry leaves the voltage command alone
    p_vchg_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        expire_now |=> $stable(vchg_word));
    // R7: a current-command write blocks expiry in its cycle
    p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == A_ICH_L || wr_addr == A_ICH_H)) |=> !wd_pulse);
    // R8: learn enable cleared while the battery is absent
    p_learn_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bat_present |=> !opt_lo[LO_LEARN]);
    // R9: current-limit enable cleared when auto-disable is set
    p_ilim_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!bat_present && opt_hi[HI_AUTODIS]) |=> !opt_lo[LO_ILIM]);

endmodule

// File: tb/chg_ctrl_regs_tb_top.sv
module chg_ctrl_regs_tb_top;
    localparam int T1 = 6;
    localparam int T2 = 11;
    localparam int T3 = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = 3'd0;
    logic [7:0]  wr_data = 8'h00;
    logic [2:0]  rd_addr = 3'd0;
    logic        tick_1ms = 1'b0;
    logic        bat_present = 1'b1;
    logic [7:0]  rd_data, opt_lo, opt_hi;
    logic [15:0] ichg_word, vchg_word, ichg_eff;
    logic        wd_pulse, wd_expired;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    bit live = 1'b0;

    // reference model state
    logic [7:0] m [0:5];
    int  mcnt;
    bit  mexp, mpulse;

    always #5 clk = ~clk;

    chg_ctrl_regs #(.WD_T1(T1), .WD_T2(T2), .WD_T3(T3)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tick_1ms(tick_1ms), .bat_present(bat_present),
        .opt_lo(opt_lo), .opt_hi(opt_hi), .ichg_word(ichg_word),
        .vchg_word(vchg_word), .ichg_eff(ichg_eff),
        .wd_pulse(wd_pulse), .wd_expired(wd_expired));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int limit_of(input logic [1:0] s);
        case (s)
            2'b01:   return T1;
            2'b10:   return T2;
            2'b11:   return T3;
            default: return 0;
        endcase
    endfunction

    // behavioural model, updated on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m[0] = 8'h0E; m[1] = 8'hE7; m[2] = 0; m[3] = 0; m[4] = 0; m[5] = 0;
            mcnt = 0; mexp = 0; mpulse = 0;
        end else begin
            logic [7:0] n [0:5];
            bit refr, expire;
            int lim;
            for (int i = 0; i < 6; i++) n[i] = m[i];
            refr = wr_en && wr_addr >= 1 && wr_addr <= 5;
            lim = limit_of(m[1][6:5]);
            expire = !refr && lim != 0 && !mexp && tick_1ms && (mcnt + 1 == lim);
            if (wr_en && wr_addr < 6) n[wr_addr] = wr_data;
            if (expire) begin n[2] = 0; n[3] = 0; end
            if (!bat_present) begin
                n[0][5] = 1'b0;
                if (m[1][4]) n[0][1] = 1'b0;
            end
            if (refr) begin mcnt = 0; mexp = 0; end
            else if (expire) begin mcnt = 0; mexp = 1; end
            else if (lim == 0) mcnt = 0;
            else if (!mexp && tick_1ms) mcnt++;
            mpulse = expire;
            for (int i = 0; i < 6; i++) m[i] = n[i];
        end
    end

    // compare against the model on every clock
    always @(negedge clk) begin
        if (live && rst_n) begin
            chk("R2 opt_lo", opt_lo, m[0]);
            chk("R2 opt_hi", opt_hi, m[1]);
            chk("R4 ichg", ichg_word, {m[3], m[2]});
            chk("R2 vchg", vchg_word, {m[5], m[4]});
            chk("R4 pulse", wd_pulse, mpulse);
            chk("R5 expired", wd_expired, mexp);
            chk("R10 ichg_eff", ichg_eff, m[0][0] ? 16'h0 : {m[3], m[2]});
            chk("R11 rd_data", rd_data, (rd_addr < 6) ? m[rd_addr] : 8'h00);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #2;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        @(posedge clk); #2;
        rd_addr = a;
        @(negedge clk);
        chk(req, rd_data, exp);
    endtask

    // counts clocks after a refresh until the flag is seen
    task automatic measure(input string req, input int exp);
        int seen = 0;
        for (int n = 1; n <= 60; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (wd_expired) begin seen = n; break; end
        end
        chk(req, seen, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        live = 1'b1;
        @(negedge clk);
        chk("R1 opt_lo reset", opt_lo, 8'h0E);
        chk("R1 opt_hi reset", opt_hi, 8'hE7);
        chk("R1 ichg reset", ichg_word, 16'h0);
        chk("R1 vchg reset", vchg_word, 16'h0);
        chk("R1 expired reset", wd_expired, 1'b0);

        // R2 R11 byte map
        wr(3'd2, 8'h34); wr(3'd3, 8'h12); wr(3'd4, 8'h68); wr(3'd5, 8'h10);
        wr(3'd6, 8'hFF); wr(3'd7, 8'hAA);
        rd_chk("R2 ichg high", 3'd3, 8'h12);
        rd_chk("R11 addr6 reads zero", 3'd6, 8'h00);
        rd_chk("R2 vchg low", 3'd4, 8'h68);

        // R3 select 01
        tick_1ms = 1'b1;
        wr(3'd1, 8'hA7);
        measure("R3 sel01 distance", T1);
        chk("R4 ichg zeroed", ichg_word, 16'h0);
        chk("R4 vchg kept", vchg_word, 16'h1068);
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk("R5 expired sticky", wd_expired, 1'b1);
        chk("R4 pulse gone", wd_pulse, 1'b0);
        wr(3'd2, 8'h55);
        chk("R5 refresh clears", wd_expired, 1'b0);

        // R3 select 10 and 11
        wr(3'd1, 8'hC7);
        measure("R3 sel10 distance", T2);
        wr(3'd1, 8'hE7);
        measure("R3 sel11 distance", T3);

        // R6 select 00
        wr(3'd2, 8'h77);
        wr(3'd1, 8'h87);
        repeat (40) @(posedge clk);
        @(negedge clk);
        chk("R6 no expiry when off", wd_expired, 1'b0);
        chk("R6 ichg intact", ichg_word, 16'h0077);

        // R7 write on the expiry clock
        wr(3'd1, 8'hA7);
        repeat (T1 - 1) @(posedge clk);
        #2 wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h99;
        @(posedge clk); #2 wr_en = 1'b0;
        @(negedge clk);
        chk("R7 no pulse", wd_pulse, 1'b0);
        chk("R7 write kept", ichg_word[7:0], 8'h99);
        measure("R7 distance after write", T1);

        // sparse ticks
        wr(3'd2, 8'h11);
        for (int c = 0; c < 3 * T1; c++) begin
            @(posedge clk); #2 tick_1ms = (c % 3 == 0);
        end
        @(posedge clk); #2 tick_1ms = 1'b0;
        @(negedge clk);
        chk("R3 sparse ticks expire", wd_expired, 1'b1);

        // R8 R9 battery absent, auto-disable on
        wr(3'd1, 8'h97);
        wr(3'd0, 8'h2E);
        @(posedge clk); #2 bat_present = 1'b0;
        @(posedge clk); #2;
        @(negedge clk);
        chk("R8 learn cleared", opt_lo[5], 1'b0);
        chk("R9 ilim cleared", opt_lo[1], 1'b0);
        wr(3'd0, 8'h22);
        chk("R8 learn write ignored while absent", opt_lo[5], 1'b0);
        @(posedge clk); #2 bat_present = 1'b1;
        wr(3'd0, 8'h22);
        chk("R9 host sets ilim again", opt_lo[1], 1'b1);
        // auto-disable off
        wr(3'd1, 8'h87);
        @(posedge clk); #2 bat_present = 1'b0;
        @(posedge clk); #2 bat_present = 1'b1;
        @(negedge clk);
        chk("R8 learn cleared again", opt_lo[5], 1'b0);
        chk("R9 ilim kept without auto", opt_lo[1], 1'b1);

        // R10 inhibit
        wr(3'd2, 8'h42); wr(3'd3, 8'h03);
        wr(3'd0, 8'h03);
        chk("R10 inhibited", ichg_eff, 16'h0);
        wr(3'd0, 8'h02);
        chk("R10 passes command", ichg_eff, 16'h0342);

        // R11 sweep
        for (int a = 0; a < 8; a++) begin
            @(posedge clk); #2 rd_addr = 3'(a);
        end
        repeat (2) @(posedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule